// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip: a sixteen-state controller stepped by the test clock, a two-bit instruction register and two internal data registers. The data registers are a one-bit bypass stage and a 32-bit identification register. Four instructions are decoded. Two of them hand the data path to an external boundary-scan chain. For these the block issues capture, shift and update strobes and routes the chain's serial output to the test data output pin.

A board tester drives `tms` and `tdi` against rising `tck` edges and reads `tdo` after falling edges. Pulling `trst_n` low at any moment returns the port to its reset state without a clock. After reset, the identification register can be read out without first loading an instruction. The opcode map is fixed and is not the common all-ones-for-bypass-only layout. All zeros selects external test and `10` selects identification.

Top module: `scan_tap_ctrl`

## Requirements
- R1: From any controller state, five consecutive rising `tck` edges with `tms` high put the controller into Test-Logic-Reset.
- R2: `trst_n` low resets the controller to Test-Logic-Reset asynchronously and at once forces `tdo_en` and `tdo` low.
- R3: In Test-Logic-Reset the current instruction becomes IDCODE, so a data scan straight after reset reads the identification register.
- R4: Capture-IR loads the pattern `01` into the instruction shift register. In Shift-IR it is shifted out least significant bit first, so `1` appears before `0`.
- R5: The opcode shifted in (LSB first) becomes current at the Update-IR edge. The codes are `00` EXTEST, `01` SAMPLE/PRELOAD, `10` IDCODE and `11` BYPASS.
- R6: Capture-DR under IDCODE loads 32 bits: bits 31..28 hold the version (default 0), bits 27..16... more precisely bits 27..12 hold the `PART_NUM` parameter, bits 11..1 hold 0x0E5 and bit 0 holds 1. Bits leave LSB first and are followed by `tdi` delayed 32 clocks.
- R7: Under BYPASS a single register captures 0 in Capture-DR, so the first bit out is 0 and `tdo` then repeats `tdi` one shift clock later.
- R8: Under EXTEST or SAMPLE/PRELOAD, `bsr_capture`, `bsr_shift` and `bsr_update` are high while the controller is in Capture-DR, Shift-DR and Update-DR respectively, and `tdo` carries `bsr_tdo`. Under the other two instructions the three strobes stay low.
- R9: `extest_mode` is high exactly while EXTEST is the current instruction.
- R10: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is high exactly while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for the tdo pad driver |
| bsr_tdo | input | 1 | Serial output of the external boundary-scan chain |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| extest_mode | output | 1 | Boundary cells drive the pins from their update latches |

## Verification
Directed scans read the identification register straight after reset and with extra bits appended. This separates the captured constant from the one-bit-per-clock pass-through that follows it. Random loops then load each of the four opcodes in turn and scan random lengths of random data. The scanned output tells the one-clock bypass delay apart from the 32-clock ID path and from the boundary chain's own output. The strobe counts show whether the boundary chain was addressed at all. Random walks on `tms` ending in five high clocks, and a reset pulled in the middle of a shift, both have to land back on IDCODE. The two paths differ in one respect: one is synchronous, the other needs no clock.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int IR_W = 2;
    localparam int ID_W = 32;
    localparam int VER_W = 4;
    localparam int PART_W = 16;
    localparam int MFR_W = ID_W - VER_W - PART_W - 1;
    localparam logic [MFR_W-1:0] MFR_CODE = MFR_W'(11'h0E5);

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 2'b00,
        OP_SAMPLE = 2'b01,
        OP_IDCODE = 2'b10,
        OP_BYPASS = 2'b11
    } tap_op_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);
    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RESET:    r_d.st = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     r_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   r_d.st = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   r_d.st = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: r_d.st = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: r_d.st = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: r_d.st = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: r_d.st = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   r_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   r_d.st = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   r_d.st = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: r_d.st = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: r_d.st = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: r_d.st = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: r_d.st = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   r_d.st = tms ? ST_SEL_DR   : ST_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q.st <= ST_RESET;
        else         r_q    <= r_d;
    end

    assign state_o = r_q.st;

    // R1
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_o == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    output tap_op_e    op_o,
    output logic       sr_lsb_o
);
    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0] sr;
        tap_op_e         op;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_i)
            ST_RESET:    r_d.op = OP_IDCODE;
            ST_CAP_IR:   r_d.sr = CAP_PAT;
            ST_SHIFT_IR: r_d.sr = {tdi, r_q.sr[IR_W-1:1]};
            ST_UPD_IR:   r_d.op = tap_op_e'(r_q.sr);
            default:     ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sr <= '0;
            r_q.op <= OP_IDCODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign op_o     = r_q.op;
    assign sr_lsb_o = r_q.sr[0];

    // R4
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_IR) |=> (r_q.sr == CAP_PAT));

    // R3
    reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_RESET) |=> (op_o == OP_IDCODE));

    // R5
    ir_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_UPD_IR) |=> (op_o == tap_op_e'($past(r_q.sr))));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [PART_W-1:0] PART_NUM = 16'hC3A5,
    parameter logic [VER_W-1:0]  VERSION  = 4'h0
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    input  tap_op_e    op_i,
    input  logic       bsr_tdo_i,
    output logic       dr_lsb_o,
    output logic       bsr_capture_o,
    output logic       bsr_shift_o,
    output logic       bsr_update_o
);
    localparam logic [ID_W-1:0] ID_VAL = {VERSION, PART_NUM, MFR_CODE, 1'b1};

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id_sr;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic     bsr_sel;

    always_comb begin
        r_d = r_q;
        if (state_i == ST_CAP_DR) begin
            if (op_i == OP_BYPASS) r_d.byp   = 1'b0;
            if (op_i == OP_IDCODE) r_d.id_sr = ID_VAL;
        end else if (state_i == ST_SHIFT_DR) begin
            if (op_i == OP_BYPASS) r_d.byp   = tdi;
            if (op_i == OP_IDCODE) r_d.id_sr = {tdi, r_q.id_sr[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        case (op_i)
            OP_BYPASS: dr_lsb_o = r_q.byp;
            OP_IDCODE: dr_lsb_o = r_q.id_sr[0];
            default:   dr_lsb_o = bsr_tdo_i;
        endcase
    end

    assign bsr_sel       = (op_i == OP_EXTEST) || (op_i == OP_SAMPLE);
    assign bsr_capture_o = bsr_sel && (state_i == ST_CAP_DR);
    assign bsr_shift_o   = bsr_sel && (state_i == ST_SHIFT_DR);
    assign bsr_update_o  = bsr_sel && (state_i == ST_UPD_DR);

    // R7
    bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && op_i == OP_BYPASS) |=> (r_q.byp == 1'b0));

    // R6
    id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && op_i == OP_IDCODE) |=> (r_q.id_sr[0] == 1'b1));

    // R8
    strobe_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o}));
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import tap_pkg::*;
#(
    parameter logic [15:0] PART_NUM = 16'hC3A5,
    parameter logic [3:0]  VERSION  = 4'h0
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic bsr_tdo,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic extest_mode
);
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    tap_state_e state;
    tap_op_e    op;
    logic       ir_lsb;
    logic       dr_lsb;
    out_regs_t  o_d, o_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    tap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state_i  (state),
        .op_o     (op),
        .sr_lsb_o (ir_lsb)
    );

    tap_dr #(
        .PART_NUM (PART_NUM),
        .VERSION  (VERSION)
    ) u_dr (
        .tck           (tck),
        .trst_n        (trst_n),
        .tdi           (tdi),
        .state_i       (state),
        .op_i          (op),
        .bsr_tdo_i     (bsr_tdo),
        .dr_lsb_o      (dr_lsb),
        .bsr_capture_o (bsr_capture),
        .bsr_shift_o   (bsr_shift),
        .bsr_update_o  (bsr_update)
    );

    always_comb begin
        o_d = '0;
        if (state == ST_SHIFT_IR) begin
            o_d.tdo = ir_lsb;
            o_d.en  = 1'b1;
        end else if (state == ST_SHIFT_DR) begin
            o_d.tdo = dr_lsb;
            o_d.en  = 1'b1;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo         = o_q.tdo;
    assign tdo_en      = o_q.en;
    assign extest_mode = (op == OP_EXTEST);

    // R10
    tdo_en_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SHIFT_DR || state == ST_SHIFT_IR));

    // R10
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> (tdo == 1'b0));
endmodule

// File: tb/scan_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb_top;
    localparam logic [15:0] TB_PART = 16'hC3A5;
    localparam logic [1:0] OP_EXT = 2'b00, OP_SMP = 2'b01, OP_IDC = 2'b10, OP_BYP = 2'b11;

    logic tck = 1'b0;
    logic trst_n, tms, tdi, bsr_tdo;
    logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, extest_mode;

    int n_chk = 0;
    int n_fail = 0;
    int edge_bad = 0;
    bit done = 0;

    logic s_tdo, s_en, s_cap, s_sh, s_upd, s_bsr;

    always #4 tck = ~tck;

    scan_tap_ctrl #(.PART_NUM(TB_PART), .VERSION(4'h0)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .bsr_tdo(bsr_tdo), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .extest_mode(extest_mode)
    );

    function automatic logic [31:0] exp_id();
        return {4'h0, TB_PART, 11'h0E5, 1'b1};
    endfunction

    function automatic logic [63:0] exp_dr(logic [1:0] op, int n, logic [63:0] din, logic [63:0] bexp);
        logic [63:0] r = '0;
        logic [31:0] id = exp_id();
        for (int i = 0; i < n; i++) begin
            case (op)
                OP_BYP:  r[i] = (i == 0) ? 1'b0 : din[i-1];
                OP_IDC:  r[i] = (i < 32) ? id[i] : din[i-32];
                default: r[i] = bexp[i];
            endcase
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic tms_v, input logic tdi_v);
        @(negedge tck); #1;
        s_tdo = tdo; s_en = tdo_en; s_cap = bsr_capture; s_sh = bsr_shift;
        s_upd = bsr_update; s_bsr = bsr_tdo;
        tms = tms_v; tdi = tdi_v; bsr_tdo = 1'($urandom_range(1));
        @(posedge tck); #1;
        if (tdo !== s_tdo) edge_bad++;
    endtask

    task automatic scan_ir(input logic [1:0] op, output logic [1:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 2; i++) begin
            tick(i == 1, op[i]);
            cap[i] = s_tdo;
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                           output logic [63:0] bexp, output int ncap, output int nsh,
                           output int nupd, output int nen);
        dout = '0; bexp = '0; ncap = 0; nsh = 0; nupd = 0; nen = 0;
        tick(1, 0); nen += int'(s_en);
        tick(0, 0); nen += int'(s_en);
        tick(0, 0); ncap += int'(s_cap); nen += int'(s_en);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            dout[i] = s_tdo; bexp[i] = s_bsr;
            nsh += int'(s_sh); nen += int'(s_en);
        end
        tick(1, 0); nen += int'(s_en);
        tick(0, 0); nupd += int'(s_upd); nen += int'(s_en);
    endtask

    task automatic check_dr(input logic [1:0] op, input int n, input string req);
        logic [63:0] din, dout, bexp, exp, mask;
        int ncap, nsh, nupd, nen;
        bit bsr;
        din = {$urandom, $urandom};
        scan_dr(n, din, dout, bexp, ncap, nsh, nupd, nen);
        mask = (n >= 64) ? '1 : ((64'd1 << n) - 1);
        exp = exp_dr(op, n, din, bexp);
        chk((dout & mask) === exp, req, dout & mask, exp);
        bsr = (op == OP_EXT) || (op == OP_SMP);
        chk(ncap == (bsr ? 1 : 0) && nsh == (bsr ? n : 0) && nupd == (bsr ? 1 : 0),
            "R8 strobes", 64'(ncap * 10000 + nsh * 10 + nupd),
            64'(bsr ? 10000 + n * 10 + 1 : 0));
        chk(nen == n, "R10 tdo_en only in shift", 64'(nen), 64'(n));
    endtask

    initial begin
        logic [1:0] cap;
        logic [1:0] op;
        int seed_v;
        seed_v = $urandom(32'h1D2C3B4A);
        trst_n = 0; tms = 1; tdi = 0; bsr_tdo = 0;
        repeat (3) @(posedge tck);
        #2;
        chk(tdo_en === 0 && tdo === 0, "R2 reset outputs", {tdo_en, tdo}, 0);
        chk(extest_mode === 0 && bsr_capture === 0 && bsr_shift === 0 && bsr_update === 0,
            "R9 reset idle", {extest_mode, bsr_capture, bsr_shift, bsr_update}, 0);
        @(negedge tck); trst_n = 1;
        tick(0, 0);

        // R3 R6: ID straight after reset, then with pass-through tail
        check_dr(OP_IDC, 32, "R3 R6 idcode after reset");
        check_dr(OP_IDC, 44, "R6 idcode with tail");

        // R4 R7: bypass
        scan_ir(OP_BYP, cap);
        chk(cap === 2'b01, "R4 capture pattern", cap, 2'b01);
        check_dr(OP_BYP, 16, "R7 bypass");
        chk(edge_bad == 0, "R10 tdo stable on rising edge", 64'(edge_bad), 0);

        // R5 R8 R9: random instruction and scan mix
        for (int it = 0; it < 60; it++) begin
            op = 2'($urandom_range(3));
            scan_ir(op, cap);
            chk(cap === 2'b01, "R4 capture pattern", cap, 2'b01);
            chk(extest_mode === (op == OP_EXT), "R9 extest_mode", extest_mode, op == OP_EXT);
            check_dr(op, 1 + $urandom_range(47), "R5 R7 R8 data path");
        end

        // R1: random walk then five tms-high clocks
        for (int it = 0; it < 8; it++) begin
            scan_ir(OP_EXT, cap);
            for (int k = 0; k < 7; k++) tick(1'($urandom_range(1)), 1'($urandom_range(1)));
            repeat (5) tick(1, 0);
            tick(0, 0);
            chk(extest_mode === 0, "R1 five tms reset", extest_mode, 0);
            check_dr(OP_IDC, 32, "R1 R3 idcode after tms reset");
        end

        // R2: asynchronous reset mid-shift
        scan_ir(OP_BYP, cap);
        tick(1, 0); tick(0, 0); tick(0, 1); tick(0, 1);
        @(negedge tck); #2;
        chk(tdo_en === 1, "R10 enable in shift", tdo_en, 1);
        trst_n = 0; #1;
        chk(tdo_en === 0 && tdo === 0, "R2 async reset", {tdo_en, tdo}, 0);
        @(posedge tck); #2; trst_n = 1;
        tick(0, 0);
        check_dr(OP_IDC, 32, "R2 R3 idcode after trst");
        chk(edge_bad == 0, "R10 tdo stable on rising edge", 64'(edge_bad), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule